// File: doc/BRIEF.md
# Half-Rate Double-Circulant Block Codec

This block holds two independent combinational paths for a binary (12,6,4) code: an encoder and a decoder. The generator is a 6x6 identity beside a 6x6 circulant. The circulant is formed from one parameterised row and its cyclic rotations, and the code is self-dual. The encoder maps a 6-bit message onto a 12-bit codeword. The decoder takes any 12-bit word and returns its best estimate of the message, along with two status flags.

The decoder forms a syndrome by recomputing parity from the received message half and comparing it with the received parity half. It then classifies that syndrome:

- A syndrome of zero means the word is clean.
- A single set bit points to a damaged parity bit.
- A syndrome equal to one of the circulant rows points to a damaged message bit, and that bit is flipped back.
- Any other pattern is reported as uncorrectable.

Neither path has a clock or any registers. The surrounding logic samples the outputs whenever it needs them.

Top module: `dcirc_codec`

## Requirements
- R1: Codeword bits [11:6] equal the 6-bit message unchanged.
- R2: Codeword parity bit j (j = 0..5) is the XOR over i of msg[i] AND ROW[(j-i) mod 6], where ROW is the first-row parameter, default 6'b011111. Equivalently, row i of the circulant is ROW rotated left by i.
- R3: A valid codeword at the decoder returns bits [11:6] as the message, with both flags low.
- R4: A word with exactly one flipped bit in [5:0] returns the original message, with the corrected flag high and the uncorrectable flag low.
- R5: A word with exactly one flipped bit in [11:6] returns the original message with that bit restored, with the corrected flag high and the uncorrectable flag low.
- R6: A word with any two flipped bits raises the uncorrectable flag, keeps the corrected flag low, and returns received bits [11:6] without change.
- R7: The corrected and uncorrectable flags are never high together.
- R8: Every nonzero codeword has at least four set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_msg_i | input | 6 | Message to encode |
| enc_code_o | output | 12 | Codeword: message in [11:6], parity in [5:0] |
| dec_word_i | input | 12 | Received word to decode |
| dec_msg_o | output | 6 | Decoded message |
| dec_corrected_o | output | 1 | A single-bit error was found and repaired |
| dec_uncorr_o | output | 1 | Syndrome matched no correctable pattern |

## Verification
The hardest cases to reach are the double errors whose syndrome could look like a single error. One example is a message-bit error combined with a parity-bit error, where the two cancel into a weight-4 or weight-6 syndrome. Another is two message-bit errors, whose rows sum to a weight-2 pattern. The bench reaches every such case by walking all 64 messages, and for each message it applies every one of the 66 two-bit error positions as well as all 12 single-bit positions.

// File: rtl/dcirc_codec.sv
module dcirc_codec #(
  parameter int K = 6,
  parameter logic [K-1:0] ROW = 6'b011111,
  localparam int N = 2 * K
) (
  input  logic [K-1:0] enc_msg_i,
  output logic [N-1:0] enc_code_o,
  input  logic [N-1:0] dec_word_i,
  output logic [K-1:0] dec_msg_o,
  output logic         dec_corrected_o,
  output logic         dec_uncorr_o
);

  function automatic logic [K-1:0] rotl(input logic [K-1:0] v, input int s);
    logic [N-1:0] t;
    t = {v, v} >> (K - s);
    return t[K-1:0];
  endfunction

  function automatic logic [K-1:0] parity_of(input logic [K-1:0] m);
    logic [K-1:0] p;
    p = '0;
    for (int i = 0; i < K; i++)
      if (m[i]) p = p ^ rotl(ROW, i);
    return p;
  endfunction

  logic [K-1:0] rx_msg, rx_par, syn, hit;
  logic         par_err;

  assign enc_code_o = {enc_msg_i, parity_of(enc_msg_i)};

  assign rx_msg = dec_word_i[N-1:K];
  assign rx_par = dec_word_i[K-1:0];
  assign syn    = rx_par ^ parity_of(rx_msg);

  for (genvar gi = 0; gi < K; gi++) begin : g_match
    assign hit[gi] = (syn == rotl(ROW, gi));
  end

  assign par_err         = $onehot(syn);
  assign dec_msg_o       = rx_msg ^ hit;
  assign dec_corrected_o = par_err | (|hit);
  assign dec_uncorr_o    = (|syn) & ~dec_corrected_o;

endmodule

// File: rtl/dcirc_codec_chk.sv
module dcirc_codec_chk #(
  parameter int K = 6,
  localparam int N = 2 * K
) (
  input logic [K-1:0] enc_msg_i,
  input logic [N-1:0] enc_code_o,
  input logic [N-1:0] dec_word_i,
  input logic [K-1:0] dec_msg_o,
  input logic         dec_corrected_o,
  input logic         dec_uncorr_o
);

  always_comb begin
    if (enc_msg_i != '0)
      a_r8_min_weight: assert ($countones(enc_code_o) >= 4);
    if (dec_uncorr_o)
      a_r6_raw_pass: assert (dec_msg_o == dec_word_i[N-1:K]);
    if (!dec_uncorr_o && !dec_corrected_o)
      a_r3_clean_pass: assert (dec_msg_o == dec_word_i[N-1:K]);
    if (dec_corrected_o)
      a_r5_one_flip: assert ($countones(dec_msg_o ^ dec_word_i[N-1:K]) <= 1);
  end

endmodule

bind dcirc_codec dcirc_codec_chk #(.K(K)) chk_i (.*);

// File: tb/dcirc_codec_tb.sv
module dcirc_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] ROW = 6'b011111;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [5:0]  enc_msg;
  logic [11:0] enc_code;
  logic [11:0] dec_word;
  logic [5:0]  dec_msg;
  logic        corr, uncorr;

  int n_chk = 0;
  int n_err = 0;

  dcirc_codec dut_i (
    .enc_msg_i(enc_msg), .enc_code_o(enc_code),
    .dec_word_i(dec_word), .dec_msg_o(dec_msg),
    .dec_corrected_o(corr), .dec_uncorr_o(uncorr)
  );

  function automatic logic [5:0] ref_par(input logic [5:0] m);
    logic [5:0] p = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 6; i++)
        p[j] = p[j] ^ (m[i] & ROW[(j - i + 6) % 6]);
    return p;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] m, input logic [11:0] w);
    @(posedge clk);
    enc_msg  <= m;
    dec_word <= w;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [11:0] cw, w;
    enc_msg  = '0;
    dec_word = '0;
    apply(6'd0, 12'd0);
    check("R3 zero word", {4'd0, corr, uncorr, dec_msg}, 12'd0);
    for (int m = 0; m < 64; m++) begin
      cw = {m[5:0], ref_par(m[5:0])};
      apply(m[5:0], cw);
      check("R1 message half", {6'd0, enc_code[11:6]}, {6'd0, m[5:0]});
      check("R2 parity half", {6'd0, enc_code[5:0]}, {6'd0, cw[5:0]});
      if (m != 0) check("R8 weight>=4", {11'd0, $countones(enc_code) >= 4}, 12'd1);
      check("R3 clean decode", {4'd0, corr, uncorr, dec_msg}, {4'd0, 2'b00, m[5:0]});
      for (int p = 0; p < 12; p++) begin
        w = cw ^ (12'd1 << p);
        apply(m[5:0], w);
        if (p < 6) check("R4 parity error", {4'd0, corr, uncorr, dec_msg}, {4'd0, 2'b10, m[5:0]});
        else       check("R5 message error", {4'd0, corr, uncorr, dec_msg}, {4'd0, 2'b10, m[5:0]});
        check("R7 flags exclusive", {11'd0, corr & uncorr}, 12'd0);
        for (int q = p + 1; q < 12; q++) begin
          w = cw ^ (12'd1 << p) ^ (12'd1 << q);
          apply(m[5:0], w);
          check("R6 double error", {4'd0, corr, uncorr, dec_msg}, {4'd0, 2'b01, w[11:6]});
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule